// File: doc/BRIEF.md
# PLL and DUT Reset Sequencing Register Block

This block sits behind an AXI4-Lite slave port and lets host software bring up a clock-generating PLL and then the logic it clocks. Software first writes and reads back a scratch identification word to prove that the register path works. It then programs a hold length and fires a self-clearing PLL reset pulse of that many cycles. Next it polls a synchronized lock flag. Only after the lock flag reads 1 does it release the active-low reset of the design under test, which has its own register.

The pulse can be fired again at any time with a new length, for example when the PLL fails to lock. At power-up every register is zero, so the DUT starts held in reset and the PLL reset starts low.

Top module: `pll_rst_seq`

## Requirements
- R1: After reset, pllReset is 0 and dutResetN is 0, and every readable register returns 0 (the lock flag returns 0 while lockAsync is 0).
- R2: The 32-bit word at byte offset 0x00 is a scratch register. A write stores the whole word and a read returns it unchanged.
- R3: The 32-bit word at offset 0x04 holds the pulse length in cycles. It can be read back.
- R4: A write with bit 0 set to offset 0x08 drives pllReset high from the cycle after the write for exactly as many cycles as the value held at 0x04. A write with bit 0 clear has no effect.
- R5: Bit 0 of a read at 0x08 returns 1 while the pulse is running and 0 once it has ended.
- R6: A new trigger that arrives while a pulse is running restarts the count from the current value at 0x04.
- R7: A pulse length of 0 gives a pulse of one cycle.
- R8: lockAsync passes through a two-stage synchronizer and is read as bit 0 at offset 0x0C. This register is read-only, and writes to it are ignored.
- R9: dutResetN follows bit 0 of the register at offset 0x10, which can be read back. It does not depend on pllReset.
- R10: Writes to unmapped offsets (0x14 to 0x1C) are ignored and reads of them return 0. bresp and rresp are always 00 (OKAY).
- R11: Write address and write data are accepted in either order or in the same cycle. Each channel has at most one transaction outstanding, and bvalid and rvalid (with rdata) hold until they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | 5 | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | 5 | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| lockAsync | input | 1 | PLL lock flag from another clock domain |
| pllReset | output | 1 | Self-clearing PLL reset pulse |
| dutResetN | output | 1 | Active-low reset of the design under test |

## Verification
The bench builds the block with its default synchronizer depth of two stages and a 32-bit data word. Because the synchronizer is short, the bench can catch the exact cycle at which a lock change first shows up in a read. Because the bench uses pulse lengths of 0, 5 and tens of cycles, it can count every pulse cycle by cycle, including a restart in the middle of a pulse.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t REG_SCRATCH = ADDR_W'(8'h00);
  localparam addr_t REG_HOLD    = ADDR_W'(8'h04);
  localparam addr_t REG_CMD     = ADDR_W'(8'h08);
  localparam addr_t REG_LOCK    = ADDR_W'(8'h0C);
  localparam addr_t REG_DUT     = ADDR_W'(8'h10);

  // One write and one read strobe per cycle, from control to datapath
  typedef struct packed {
    logic  wrEn;
    addr_t wrAddr;
    data_t wrData;
    logic  rdEn;
    addr_t rdAddr;
  } strobes_t;

  function automatic addr_t alignWord(input addr_t a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/prs_ctrl.sv
module prs_ctrl
  import prs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     awvalid,
  output logic     awready,
  input  addr_t    awaddr,
  input  logic     wvalid,
  output logic     wready,
  input  data_t    wdata,
  output logic     bvalid,
  input  logic     bready,
  output logic [1:0] bresp,
  input  logic     arvalid,
  output logic     arready,
  input  addr_t    araddr,
  output logic     rvalid,
  input  logic     rready,
  output logic [1:0] rresp,
  output strobes_t strobes
);
  logic  awHeld, wHeld, bvalidQ, rvalidQ;
  addr_t awAddrQ;
  data_t wDataQ;
  logic  wrFire, rdFire;

  assign awready = !awHeld && !bvalidQ;
  assign wready  = !wHeld && !bvalidQ;
  assign wrFire  = awHeld && wHeld && !bvalidQ;
  assign arready = !rvalidQ;
  assign rdFire  = arvalid && arready;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHeld  <= 1'b0;
      wHeld   <= 1'b0;
      bvalidQ <= 1'b0;
      awAddrQ <= '0;
      wDataQ  <= '0;
    end else begin
      if (awvalid && awready) begin
        awHeld  <= 1'b1;
        awAddrQ <= awaddr;
      end
      if (wvalid && wready) begin
        wHeld  <= 1'b1;
        wDataQ <= wdata;
      end
      if (wrFire) begin
        awHeld  <= 1'b0;
        wHeld   <= 1'b0;
        bvalidQ <= 1'b1;
      end else if (bvalidQ && bready) begin
        bvalidQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rvalidQ <= 1'b0;
    else if (rdFire) rvalidQ <= 1'b1;
    else if (rvalidQ && rready) rvalidQ <= 1'b0;
  end

  assign bvalid = bvalidQ;
  assign rvalid = rvalidQ;
  assign bresp  = 2'b00;
  assign rresp  = 2'b00;

  always_comb begin
    strobes.wrEn   = wrFire;
    strobes.wrAddr = awAddrQ;
    strobes.wrData = wDataQ;
    strobes.rdEn   = rdFire;
    strobes.rdAddr = araddr;
  end
endmodule

// File: rtl/prs_datapath.sv
module prs_datapath
  import prs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strobes,
  input  logic     lockAsync,
  output data_t    rdata,
  output logic     pllReset,
  output logic     dutResetN
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic  lockSync;
  data_t scratchQ, holdQ, cntQ, rdMux;
  logic  activeQ, dutRunQ, trigger;
  addr_t wrWord, rdWord;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[g] <= 1'b0;
      else if (g == 0) syncChain[g] <= lockAsync;
      else syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
    end
  end
  assign lockSync = syncChain[SYNC_STAGES-1];

  assign wrWord  = alignWord(strobes.wrAddr);
  assign rdWord  = alignWord(strobes.rdAddr);
  assign trigger = strobes.wrEn && (wrWord == REG_CMD) && strobes.wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scratchQ <= '0;
      holdQ    <= '0;
      dutRunQ  <= 1'b0;
    end else if (strobes.wrEn) begin
      case (wrWord)
        REG_SCRATCH: scratchQ <= strobes.wrData;
        REG_HOLD:    holdQ    <= strobes.wrData;
        REG_DUT:     dutRunQ  <= strobes.wrData[0];
        default:     ;
      endcase
    end
  end

  // Pulse counter: loads the hold length (minimum 1), counts down, clears itself
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
    end else if (trigger) begin
      activeQ <= 1'b1;
      cntQ    <= (holdQ == '0) ? DATA_W'(1) : holdQ;
    end else if (activeQ) begin
      if (cntQ == DATA_W'(1)) begin
        activeQ <= 1'b0;
        cntQ    <= '0;
      end else begin
        cntQ <= cntQ - DATA_W'(1);
      end
    end
  end

  always_comb begin
    case (rdWord)
      REG_SCRATCH: rdMux = scratchQ;
      REG_HOLD:    rdMux = holdQ;
      REG_CMD:     rdMux = DATA_W'(activeQ);
      REG_LOCK:    rdMux = DATA_W'(lockSync);
      REG_DUT:     rdMux = DATA_W'(dutRunQ);
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (strobes.rdEn) rdata <= rdMux;
  end

  assign pllReset  = activeQ;
  assign dutResetN = dutRunQ;
endmodule

// File: rtl/pll_rst_seq.sv
module pll_rst_seq
  import prs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        awvalid,
  output logic        awready,
  input  logic [4:0]  awaddr,
  input  logic        wvalid,
  output logic        wready,
  input  logic [31:0] wdata,
  output logic        bvalid,
  input  logic        bready,
  output logic [1:0]  bresp,
  input  logic        arvalid,
  output logic        arready,
  input  logic [4:0]  araddr,
  output logic        rvalid,
  input  logic        rready,
  output logic [31:0] rdata,
  output logic [1:0]  rresp,
  input  logic        lockAsync,
  output logic        pllReset,
  output logic        dutResetN
);
  strobes_t strobes;

  prs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rresp(rresp),
    .strobes(strobes)
  );

  prs_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lockAsync(lockAsync),
    .rdata(rdata), .pllReset(pllReset), .dutResetN(dutResetN)
  );
endmodule

// File: rtl/prs_checker.sv
module prs_checker
  import prs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic [1:0]  rresp,
  input logic        pllReset,
  input logic        dutResetN,
  input strobes_t    strobes
);
  assert_bresp_okay_R10: assert property (@(posedge clk) disable iff (!rstN)
    bvalid |-> bresp == 2'b00);
  assert_rresp_okay_R10: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |-> rresp == 2'b00);
  assert_b_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    bvalid && !bready |=> bvalid);
  assert_r_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    rvalid && !rready |=> rvalid && $stable(rdata));
  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllReset) |-> $past(strobes.wrEn && alignWord(strobes.wrAddr) == REG_CMD
                              && strobes.wrData[0]));
  assert_dut_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dutResetN) |-> $past(strobes.wrEn && alignWord(strobes.wrAddr) == REG_DUT
                               && strobes.wrData[0]));
  assert_dut_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dutResetN) |-> $past(strobes.wrEn && alignWord(strobes.wrAddr) == REG_DUT
                               && !strobes.wrData[0]));
endmodule

bind pll_rst_seq prs_checker u_chk (
  .clk(clk), .rstN(rstN), .bvalid(bvalid), .bready(bready), .bresp(bresp),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
  .pllReset(pllReset), .dutResetN(dutResetN), .strobes(strobes)
);

// File: tb/pll_rst_seq_tb.sv
module pll_rst_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, awvalid, awready, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready, lockAsync, pllReset, dutResetN;
  logic [4:0] awaddr, araddr;
  logic [31:0] wdata, rdata;
  logic [1:0] bresp, rresp;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  pll_rst_seq u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each accepted read beat
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rstN && rvalid && rready) begin
      if (expQ.size() == 0) check(1'b0, "R10 unexpected read beat", rdata, 0);
      else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdata === e && rresp == 2'b00, t, rdata, e);
      end
    end
  end

  task automatic sendAw(input logic [4:0] a);
    bit hs;
    awaddr = a; awvalid = 1'b1;
    while (1) begin
      hs = awready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    @(negedge clk);
    awvalid = 1'b0;
  endtask

  task automatic sendW(input logic [31:0] d);
    bit hs;
    wdata = d; wvalid = 1'b1;
    while (1) begin
      hs = wready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    @(negedge clk);
    wvalid = 1'b0;
  endtask

  // order: 0 same cycle, 1 address first, 2 data first (R11)
  task automatic writeReg(input logic [4:0] a, input logic [31:0] d, input int order);
    case (order)
      1: begin sendAw(a); sendW(d); end
      2: begin sendW(d); sendAw(a); end
      default: fork sendAw(a); sendW(d); join
    endcase
    while (!bvalid) @(negedge clk);
    check(bresp == 2'b00, "R10 R11 write response", 32'(bresp), 0);
  endtask

  task automatic readReg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bit hs;
    araddr = a; arvalid = 1'b1;
    while (1) begin
      hs = arready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    arvalid = 1'b0;
  endtask

  task automatic measurePulse(output int n);
    n = 0;
    while (pllReset && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int n;
    rstN = 1'b0; awvalid = 0; wvalid = 0; arvalid = 0; bready = 1; rready = 1;
    awaddr = 0; araddr = 0; wdata = 0; lockAsync = 0;
    repeat (4) @(negedge clk);
    check(pllReset == 0, "R1 pllReset in reset", 32'(pllReset), 0);
    check(dutResetN == 0, "R1 dutResetN in reset", 32'(dutResetN), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pllReset == 0 && dutResetN == 0, "R1 outputs after reset",
          {30'd0, pllReset, dutResetN}, 0);
    readReg(5'h00, 0, "R1 scratch zero");
    readReg(5'h04, 0, "R1 hold zero");
    readReg(5'h08, 0, "R1 cmd zero");
    readReg(5'h0C, 0, "R1 lock zero");
    readReg(5'h10, 0, "R1 dut zero");

    writeReg(5'h00, 32'hA5A5_1234, 0);
    readReg(5'h00, 32'hA5A5_1234, "R2 scratch same-cycle R11");
    writeReg(5'h00, 32'h5A5A_F00D, 2);
    readReg(5'h00, 32'h5A5A_F00D, "R2 scratch data-first R11");

    writeReg(5'h04, 32'd5, 1);
    readReg(5'h04, 32'd5, "R3 hold address-first R11");

    writeReg(5'h08, 32'd0, 0);
    repeat (3) @(negedge clk);
    check(pllReset == 0, "R4 clear bit no pulse", 32'(pllReset), 0);
    writeReg(5'h08, 32'd1, 0);
    measurePulse(n);
    check(n == 5, "R4 pulse length", n, 5);

    writeReg(5'h04, 32'd40, 0);
    writeReg(5'h08, 32'd1, 0);
    readReg(5'h08, 32'd1, "R5 busy reads 1");
    while (pllReset) @(negedge clk);
    readReg(5'h08, 32'd0, "R5 idle reads 0");

    writeReg(5'h04, 32'd20, 0);
    writeReg(5'h08, 32'd1, 0);
    writeReg(5'h04, 32'd5, 0);
    writeReg(5'h08, 32'd1, 0);
    measurePulse(n);
    check(n == 5, "R6 retrigger restarts count", n, 5);

    writeReg(5'h04, 32'd0, 0);
    writeReg(5'h08, 32'd1, 0);
    measurePulse(n);
    check(n == 1, "R7 zero length gives one cycle", n, 1);

    lockAsync = 1'b1;
    repeat (4) @(negedge clk);
    readReg(5'h0C, 32'd1, "R8 lock visible");
    writeReg(5'h0C, 32'd0, 0);
    readReg(5'h0C, 32'd1, "R8 lock write ignored");
    lockAsync = 1'b0;
    readReg(5'h0C, 32'd1, "R8 sync delay keeps old value");
    repeat (3) @(negedge clk);
    readReg(5'h0C, 32'd0, "R8 lock cleared");

    writeReg(5'h10, 32'd1, 0);
    @(negedge clk);
    check(dutResetN == 1, "R9 dut released", 32'(dutResetN), 1);
    check(pllReset == 0, "R9 pll unaffected", 32'(pllReset), 0);
    readReg(5'h10, 32'd1, "R9 dut readback");
    writeReg(5'h10, 32'd0, 2);
    @(negedge clk);
    check(dutResetN == 0, "R9 dut held again", 32'(dutResetN), 0);

    writeReg(5'h14, 32'hFFFF_FFFF, 0);
    readReg(5'h14, 32'd0, "R10 unmapped read 0x14");
    readReg(5'h1C, 32'd0, "R10 unmapped read 0x1C");
    readReg(5'h00, 32'h5A5A_F00D, "R10 unmapped write ignored");
    check(pllReset == 0 && dutResetN == 0, "R10 outputs untouched",
          {30'd0, pllReset, dutResetN}, 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R11 all reads returned", expQ.size(), 0);
    finishRun();
  end
endmodule